// File: doc/BRIEF.md
# Camera capture event flag unit

This unit sits next to a camera capture pipe and holds the pipe's status word and its sticky raw interrupt flags. It receives event strobes from the pipe: a vertical sync level, a line-completed strobe, an end-of-frame strobe (issued after the last line of the crop window, or at the frame's end when the window is empty), a buffer overrun strobe and the running value of the pipe's data counter. From these it keeps five sticky flags (line group done, frame done, sync start, data limit reached, overrun) and a live capture-active bit.

Software drives the unit through a small register port: a control register (capture enable, embedded-sync mode, JPEG mode, line multiple), an interrupt enable register, a data limit register, a read-only status register and a separate write-one-to-clear register. A single interrupt output is the OR of the enabled flags. The line-group flag fires every N completed lines, and is also forced at the end of every frame so that a partial last group is reported.

Top module: `cam_evt_flags`

## Requirements
- R1: After reset the status register reads 0, `irq_o` is 0, the control and interrupt enable registers read 0 and the data limit register reads all ones.
- R2: Register addresses: 0 status (read only), 1 flag clear (write only, reads 0), 2 control, 3 interrupt enable, 4 data limit. Status bits: 0 capture active, 1 overrun, 2 limit, 3 sync, 4 frame done, 5 line group; all higher bits read 0. Control bits: 0 capture enable, 1 embedded-sync mode, 2 JPEG mode, bits 8 and up the line multiple. Interrupt enable and clear use the same bit positions 1 to 5 as the status flags.
- R3: The sync flag sets in the cycle after `vsync_i` is first sampled high following a sampled low; in embedded-sync mode only while capture enable is 1.
- R4: Outside JPEG mode the line-group flag sets on the line strobe that completes each group of N lines, N being the line multiple (0 acts as 1). A frame start (sync rise) resets the line count; a line strobe in the same cycle as a frame start is not counted.
- R5: A frame-end strobe always sets the line-group flag and resets the line count, whatever the count; in JPEG mode line strobes are not counted and the flag sets only at frame end.
- R6: In embedded-sync mode with capture enable 0 the line-group flag is never set; the line count still advances.
- R7: The frame-done flag sets on every frame-end strobe, in every mode and whatever capture enable is, including frames with an empty crop window.
- R8: The limit flag sets in the cycle after `dcnt_i` equals the data limit register.
- R9: The overrun flag sets in the cycle after `ovr_i` is sampled high.
- R10: A flag clears only when 1 is written to its bit in the clear register; writing 0 leaves it unchanged, and a set event in the same cycle as a clear leaves the flag set.
- R11: The capture-active bit sets on a sync rise while capture enable is 1 and clears on a frame-end strobe, unless a sync rise with capture enable comes in the same cycle.
- R12: `irq_o` is 1 exactly when some flag is 1 whose interrupt enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_i | input | 1 | Vertical sync level, active high |
| line_end_i | input | 1 | One-cycle strobe: a line inside the window completed |
| frame_end_i | input | 1 | One-cycle strobe: frame or crop window capture completed |
| ovr_i | input | 1 | One-cycle strobe: data buffer overrun |
| dcnt_i | input | CNT_W | Current data counter value of the pipe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational from address) |
| irq_o | output | 1 | OR of enabled flags |

## Verification
The bench builds the unit with a 4-bit line multiple and a 4-bit data counter. The narrow line multiple lets random runs hit the largest group size of 15 lines, the zero-means-one case and frames whose line count is not a multiple of the group, while the narrow counter makes equality with the limit register frequent enough to exercise set-versus-clear collisions on the limit flag. Directed sequences cover JPEG mode, embedded sync with capture disabled, empty frames and write-zero clears.

// File: rtl/cam_evt_pkg.sv
package cam_evt_pkg;

    // status / clear / enable bit positions
    localparam int BIT_ACT = 0;
    localparam int BIT_OVR = 1;
    localparam int BIT_LIM = 2;
    localparam int BIT_SYN = 3;
    localparam int BIT_FRM = 4;
    localparam int BIT_LGR = 5;
    localparam int NFLAG   = 5;   // sticky flags, bits 1..5

    // register addresses
    localparam int A_STAT = 0;
    localparam int A_CLR  = 1;
    localparam int A_CTRL = 2;
    localparam int A_IEN  = 3;
    localparam int A_LIM  = 4;

    // control register bit positions
    localparam int C_CAPEN = 0;
    localparam int C_EMB   = 1;
    localparam int C_JPEG  = 2;
    localparam int C_LM_LO = 8;

endpackage

// File: rtl/cam_evt_vsync.sv
module cam_evt_vsync (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    input  logic cap_en_i,
    input  logic frame_end_i,
    output logic rise_o,
    output logic active_o
);
    typedef struct packed {
        logic vs;
        logic act;
    } vs_st_t;

    vs_st_t st_d, st_q;

    assign rise_o   = vsync_i & ~st_q.vs;
    assign active_o = st_q.act;

    always_comb begin
        st_d    = st_q;
        st_d.vs = vsync_i;
        if (frame_end_i)
            st_d.act = 1'b0;
        if (rise_o && cap_en_i)
            st_d.act = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cam_evt_linegrp.sv
module cam_evt_linegrp #(
    parameter int LM_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_end_i,
    input  logic            frame_start_i,
    input  logic            frame_end_i,
    input  logic            jpeg_i,
    input  logic [LM_W-1:0] mult_i,
    output logic            fire_o
);
    localparam int CW = LM_W + 1;

    typedef struct packed {
        logic [LM_W-1:0] cnt;
    } lg_st_t;

    lg_st_t       st_d, st_q;
    logic [CW-1:0] eff_w;
    logic [CW-1:0] next_w;

    assign eff_w  = (mult_i == '0) ? CW'(1) : {1'b0, mult_i};
    assign next_w = {1'b0, st_q.cnt} + CW'(1);

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (frame_end_i) begin
            fire_o   = 1'b1;
            st_d.cnt = '0;
        end else if (frame_start_i) begin
            st_d.cnt = '0;
        end else if (line_end_i && !jpeg_i) begin
            if (next_w >= eff_w) begin
                fire_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = next_w[LM_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cam_evt_flagbank.sv
module cam_evt_flagbank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flg;
    } fb_st_t;

    fb_st_t st_d, st_q;

    assign flag_o = st_q.flg;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // set has priority over a simultaneous clear
            if (set_i[i])      st_d.flg[i] = 1'b1;
            else if (clr_i[i]) st_d.flg[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cam_evt_flags.sv
module cam_evt_flags #(
    parameter int LM_W   = 8,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              line_end_i,
    input  logic              frame_end_i,
    input  logic              ovr_i,
    input  logic [CNT_W-1:0]  dcnt_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    import cam_evt_pkg::*;

    localparam int NF = NFLAG;

    typedef struct packed {
        logic              cap_en;
        logic              emb;
        logic              jpeg;
        logic [LM_W-1:0]   lm;
        logic [NF-1:0]     ien;
        logic [CNT_W-1:0]  lim;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic          rise_w;
    logic          act_w;
    logic          fire_w;
    logic          allow_w;
    logic          cap_en_w;
    logic [NF-1:0] set_w;
    logic [NF-1:0] clr_w;
    logic [NF-1:0] flag_w;
    logic [DATA_W-1:0] stat_w;
    logic          wr_clr_w;
    logic          unused_w;

    assign cap_en_w = cfg_q.cap_en;
    assign allow_w  = ~cfg_q.emb | cfg_q.cap_en;
    assign wr_clr_w = reg_wr_i && (reg_addr_i == ADDR_W'(A_CLR));

    cam_evt_vsync u_vsync (
        .clk         (clk),
        .rst_n       (rst_n),
        .vsync_i     (vsync_i),
        .cap_en_i    (cfg_q.cap_en),
        .frame_end_i (frame_end_i),
        .rise_o      (rise_w),
        .active_o    (act_w)
    );

    cam_evt_linegrp #(.LM_W(LM_W)) u_linegrp (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_end_i    (line_end_i),
        .frame_start_i (rise_w),
        .frame_end_i   (frame_end_i),
        .jpeg_i        (cfg_q.jpeg),
        .mult_i        (cfg_q.lm),
        .fire_o        (fire_w)
    );

    // flag vector index k holds status bit k+1
    always_comb begin
        set_w                = '0;
        set_w[BIT_OVR-1]     = ovr_i;
        set_w[BIT_LIM-1]     = (dcnt_i == cfg_q.lim);
        set_w[BIT_SYN-1]     = rise_w & allow_w;
        set_w[BIT_FRM-1]     = frame_end_i;
        set_w[BIT_LGR-1]     = fire_w & allow_w;
        clr_w                = wr_clr_w ? reg_wdata_i[NF:1] : '0;
    end

    cam_evt_flagbank #(.N(NF)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_w),
        .clr_i  (clr_w),
        .flag_o (flag_w)
    );

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr_i) begin
            case (reg_addr_i)
                ADDR_W'(A_CTRL): begin
                    cfg_d.cap_en = reg_wdata_i[C_CAPEN];
                    cfg_d.emb    = reg_wdata_i[C_EMB];
                    cfg_d.jpeg   = reg_wdata_i[C_JPEG];
                    cfg_d.lm     = reg_wdata_i[C_LM_LO +: LM_W];
                end
                ADDR_W'(A_IEN): cfg_d.ien = reg_wdata_i[NF:1];
                ADDR_W'(A_LIM): cfg_d.lim = reg_wdata_i[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cfg_q.lim <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // read side
    always_comb begin
        stat_w                       = '0;
        stat_w[BIT_ACT]              = act_w;
        stat_w[NF:1]                 = flag_w;
        reg_rdata_o                  = '0;
        case (reg_addr_i)
            ADDR_W'(A_STAT): reg_rdata_o = stat_w;
            ADDR_W'(A_CTRL): begin
                reg_rdata_o[C_CAPEN]          = cfg_q.cap_en;
                reg_rdata_o[C_EMB]            = cfg_q.emb;
                reg_rdata_o[C_JPEG]           = cfg_q.jpeg;
                reg_rdata_o[C_LM_LO +: LM_W]  = cfg_q.lm;
            end
            ADDR_W'(A_IEN):  reg_rdata_o[NF:1]        = cfg_q.ien;
            ADDR_W'(A_LIM):  reg_rdata_o[CNT_W-1:0]   = cfg_q.lim;
            default: ;
        endcase
    end

    assign irq_o = |(flag_w & cfg_q.ien);

    assign unused_w = ^{reg_wdata_i, cap_en_w};
endmodule

// File: rtl/cam_evt_flags_chk.sv
module cam_evt_flags_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vsync_i,
    input logic              frame_end_i,
    input logic              ovr_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              irq_o,
    input logic [4:0]        flag_w,
    input logic              act_w,
    input logic              cap_en_w
);
    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_i |=> flag_w[0]);

    // R7
    frame_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_i |=> flag_w[3]);

    // R10
    ovr_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_w[0]) |-> $past(reg_wr_i && reg_addr_i == ADDR_W'(1) && reg_wdata_i[1]));

    // R10
    frame_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_w[3]) |-> $past(reg_wr_i && reg_addr_i == ADDR_W'(1) && reg_wdata_i[4]));

    // R11
    active_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && !vsync_i) |=> !act_w);

    // R3
    sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vsync_i) && cap_en_w) |=> flag_w[2]);

    // R12
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flag_w != 5'd0));

    // R2
    stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == ADDR_W'(0)) |-> (reg_rdata_o[DATA_W-1:6] == '0));
endmodule

bind cam_evt_flags cam_evt_flags_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_i     (vsync_i),
    .frame_end_i (frame_end_i),
    .ovr_i       (ovr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .flag_w      (flag_w),
    .act_w       (act_w),
    .cap_en_w    (cap_en_w)
);

// File: tb/cam_evt_flags_tb_top.sv
`timescale 1ns/1ps
module cam_evt_flags_tb_top;
    localparam int LM_W   = 4;
    localparam int CNT_W  = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] AS = 3'd0, AC = 3'd1, AT = 3'd2, AI = 3'd3, AL = 3'd4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              vsync_i, line_end_i, frame_end_i, ovr_i;
    logic [CNT_W-1:0]  dcnt_i;
    logic              reg_wr_i;
    logic [ADDR_W-1:0] reg_addr_i;
    logic [DATA_W-1:0] reg_wdata_i;
    logic [DATA_W-1:0] reg_rdata_o;
    logic              irq_o;

    always #2 clk = ~clk;

    cam_evt_flags #(.LM_W(LM_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .line_end_i(line_end_i),
        .frame_end_i(frame_end_i), .ovr_i(ovr_i), .dcnt_i(dcnt_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    // reference model state
    logic       m_vs, m_act, m_cap, m_emb, m_jpg;
    logic [5:1] m_flg, m_ien;
    int         m_cnt, m_lm, m_lim;
    int         checks = 0, errors = 0;
    bit         done = 0;
    logic       cur_vs = 1'b0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {26'd0, m_flg, m_act};
    endfunction

    function automatic logic exp_irq();
        return |(m_flg & m_ien);
    endfunction

    task automatic model_step(input logic vs, le, fe, ov, input logic [CNT_W-1:0] dc,
                              input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] wd);
        logic rise, allow, fire;
        logic [5:1] set, clr;
        int eff;
        rise  = vs & ~m_vs;
        allow = ~m_emb | m_cap;
        fire  = 1'b0;
        eff   = (m_lm == 0) ? 1 : m_lm;
        if (fe) begin fire = 1'b1; m_cnt = 0; end
        else if (rise) m_cnt = 0;
        else if (le && !m_jpg) begin
            if (m_cnt + 1 >= eff) begin fire = 1'b1; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end
        set = {fire & allow, fe, rise & allow, (int'(dc) == m_lim), ov};
        clr = (wr && a == AC) ? wd[5:1] : 5'd0;
        m_flg = (m_flg & ~clr) | set;
        if (fe) m_act = 1'b0;
        if (rise && m_cap) m_act = 1'b1;
        m_vs = vs;
        if (wr) begin
            case (a)
                AT: begin m_cap = wd[0]; m_emb = wd[1]; m_jpg = wd[2]; m_lm = int'(wd[8 +: LM_W]); end
                AI: m_ien = wd[5:1];
                AL: m_lim = int'(wd[CNT_W-1:0]);
                default: ;
            endcase
        end
    endtask

    // one clock: drive, advance model, compare status and irq after the edge
    task automatic cyc(input logic vs, le, fe, ov, input logic [CNT_W-1:0] dc,
                       input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                       input string tag);
        logic [31:0] st, ex;
        vsync_i = vs; line_end_i = le; frame_end_i = fe; ovr_i = ov; dcnt_i = dc;
        reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
        cur_vs = vs;
        model_step(vs, le, fe, ov, dc, wr, a, wd);
        @(posedge clk); @(negedge clk);
        reg_wr_i = 1'b0; reg_addr_i = AS; line_end_i = 1'b0; frame_end_i = 1'b0; ovr_i = 1'b0;
        #1;
        st = reg_rdata_o; ex = exp_status();
        chk({tag, " R11 capture active"}, 32'(st[0]), 32'(ex[0]));
        chk({tag, " R9 overrun"},         32'(st[1]), 32'(ex[1]));
        chk({tag, " R8 limit"},           32'(st[2]), 32'(ex[2]));
        chk({tag, " R3 sync"},            32'(st[3]), 32'(ex[3]));
        chk({tag, " R7 frame done"},      32'(st[4]), 32'(ex[4]));
        chk({tag, " R4 line group"},      32'(st[5]), 32'(ex[5]));
        chk({tag, " R2 upper bits"},      st & 32'hFFFF_FFC0, 32'd0);
        chk({tag, " R12 irq"},            32'(irq_o), 32'(exp_irq()));
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(cur_vs, 0, 0, 0, 4'd0, 0, AS, 0, tag);
    endtask

    task automatic wreg(input logic [ADDR_W-1:0] a, input logic [31:0] wd, input string tag);
        cyc(cur_vs, 0, 0, 0, 4'd0, 1, a, wd, tag);
    endtask

    task automatic line(input string tag);
        cyc(cur_vs, 1, 0, 0, 4'd0, 0, AS, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; vsync_i = 0; line_end_i = 0; frame_end_i = 0; ovr_i = 0;
        dcnt_i = '0; reg_wr_i = 0; reg_addr_i = AS; reg_wdata_i = '0;
        m_vs = 0; m_act = 0; m_cap = 0; m_emb = 0; m_jpg = 0;
        m_flg = '0; m_ien = '0; m_cnt = 0; m_lm = 0; m_lim = 15;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;

        // R1 reset state
        chk("R1 status", reg_rdata_o, 32'd0);
        chk("R1 irq", 32'(irq_o), 32'd0);
        reg_addr_i = AT; #1; chk("R1 control", reg_rdata_o, 32'd0);
        reg_addr_i = AI; #1; chk("R1 irq enable", reg_rdata_o, 32'd0);
        reg_addr_i = AL; #1; chk("R1 limit", reg_rdata_o, 32'h0000_000F);
        reg_addr_i = AC; #1; chk("R2 clear reads 0", reg_rdata_o, 32'd0);
        reg_addr_i = AS;

        // R4 groups of 3 lines, frame of 7 lines, R5 forced group at frame end
        wreg(AT, 32'h0000_0301, "R4 setup");
        wreg(AI, 32'h0000_003E, "R12 enable all");
        cyc(1, 0, 0, 0, 0, 0, AS, 0, "R3 rise");
        cur_vs = 1;
        for (int i = 0; i < 7; i++) begin
            cyc(cur_vs, 1, 0, 0, 0, 1, AC, 32'h20, "R10 line+clear");
        end
        cyc(0, 0, 1, 0, 0, 0, AS, 0, "R5 forced frame end");
        cur_vs = 0;
        idle(1, "R11 after frame");
        wreg(AC, 32'h0000_0000, "R10 write zero");
        wreg(AC, 32'h0000_003E, "R10 clear all");

        // R5 JPEG mode: lines ignored, only frame end
        wreg(AT, 32'h0000_0105, "R5 jpeg setup");
        cyc(1, 0, 0, 0, 0, 0, AS, 0, "R5 jpeg rise");
        for (int i = 0; i < 4; i++) line("R5 jpeg line");
        cyc(1, 0, 1, 0, 0, 0, AS, 0, "R5 jpeg frame end");
        cyc(0, 0, 0, 0, 0, 1, AC, 32'h3E, "R5 clear");

        // R6 embedded sync, capture disabled; R7 empty frame still flags
        wreg(AT, 32'h0000_0102, "R6 setup");
        cyc(1, 1, 0, 0, 0, 0, AS, 0, "R6 rise gated");
        line("R6 line gated");
        cyc(1, 0, 1, 0, 0, 0, AS, 0, "R7 empty frame end");
        cyc(0, 0, 0, 0, 0, 0, AS, 0, "R6 idle");
        wreg(AT, 32'h0000_0103, "R6 enable capture");
        cyc(1, 1, 0, 0, 0, 0, AS, 0, "R6 rise allowed");
        cyc(1, 0, 1, 0, 0, 0, AS, 0, "R6 frame end allowed");
        cyc(0, 0, 0, 0, 0, 1, AC, 32'h3E, "R10 clear");

        // R4 line multiple 0 acts as 1
        wreg(AT, 32'h0000_0001, "R4 lm0");
        line("R4 lm0 line"); wreg(AC, 32'h20, "R10 clear lg"); line("R4 lm0 line2");

        // R8 limit, R10 set beats clear, R9 overrun
        wreg(AL, 32'h0000_0005, "R8 limit set");
        cyc(cur_vs, 0, 0, 0, 4'd5, 0, AS, 0, "R8 hit");
        cyc(cur_vs, 0, 0, 1, 4'd5, 1, AC, 32'h06, "R10 set wins");
        cyc(cur_vs, 0, 0, 0, 4'd1, 1, AC, 32'h06, "R10 clear");
        wreg(AI, 32'h0000_0002, "R12 only ovr");
        cyc(cur_vs, 0, 1, 0, 4'd0, 0, AS, 0, "R12 masked frame");
        cyc(cur_vs, 0, 0, 1, 4'd0, 0, AS, 0, "R9 ovr");

        // random phase
        for (int n = 0; n < 3000; n++) begin
            logic vs, le, fe, ov, wr;
            logic [ADDR_W-1:0] a;
            logic [31:0] wd;
            int r;
            vs = (($urandom % 16) == 0) ? ~cur_vs : cur_vs;
            le = ($urandom % 10) < 3;
            fe = ($urandom % 30) == 0;
            ov = ($urandom % 50) == 0;
            r  = $urandom % 24;
            wr = (r < 5);
            a  = AS; wd = $urandom;
            case (r)
                0, 1: a = AC;
                2:    a = AT;
                3:    a = AI;
                4:    a = AL;
                default: ;
            endcase
            cyc(vs, le, fe, ov, 4'($urandom), wr, a, wd, "random R4 R5 R6 R10");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule